// File: doc/BRIEF.md
# Integer ALU with Signed and Unsigned Variants

This block is the combinational integer datapath of a small load/store processor. It takes two 32-bit operands and a 4-bit operation code, and it returns a 32-bit result together with an overflow-trap flag. It covers addition and subtraction in trapping and non-trapping forms, signed and unsigned set-less-than, and the four bitwise operations AND, OR, XOR and NOR.

The signed and unsigned forms of each arithmetic operation produce the same sum bits. They differ only in whether signed overflow raises the trap flag. The two compare forms differ only in how they read the operands. A small operand-preparation stage can replace the second operand with a 16-bit immediate. The immediate is zero-extended for the bitwise operations and sign-extended for every other operation, including the unsigned-named add and compare. A separate byte-extension path widens a loaded byte to 32 bits, with or without its sign.

The block only flags overflow. Whatever consumes the flag decides what happens next.

Top module: `int_alu`

## Requirements
- R1: Op code 0 (add, trapping) and op code 1 (add, non-trapping) both give result = A + B modulo 2^32, with identical result bits.
- R2: `trap_o` is 1 for op code 0 exactly when A and B have the same sign bit and the sum's sign bit differs. It is 1 for op code 2 (subtract, trapping) exactly when A and B differ in sign and the difference's sign bit differs from A's.
- R3: Op code 2 and op code 3 (subtract, non-trapping) both give result = A - B modulo 2^32. For op codes 1 and 3, `trap_o` is always 0.
- R4: Op code 4 (signed set-less-than) gives 0x00000001 when A < B as two's-complement numbers and 0x00000000 otherwise. For example, A=0xFFFFFFFF and B=0x00000001 give 0x00000001.
- R5: Op code 5 (unsigned set-less-than) gives 0x00000001 when A < B as unsigned numbers and 0x00000000 otherwise. For example, A=0xFFFFFFFF and B=0x00000001 give 0x00000000.
- R6: When `use_imm_i` is 1, the operand `imm_i` replaces B. It is zero-extended for op codes 6 to 9 and sign-extended for all other op codes, including op codes 1 and 5.
- R7: Op codes 6, 7, 8 and 9 give the bitwise AND, OR, XOR and NOR of A and B. A NOR bit is 1 only when both input bits are 0.
- R8: `byte_ext_o` is `byte_i` sign-extended when `byte_signed_i` is 1 and zero-extended when it is 0. For example, byte 0x84 gives 0xFFFFFF84 in the first case and 0x00000084 in the second.
- R9: Op codes 10 to 15 give result 0x00000000 and `trap_o` 0.
- R10: `trap_o` can be 1 only for op codes 0 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second register operand |
| imm_i | input | 16 | Immediate operand |
| use_imm_i | input | 1 | Selects the extended immediate in place of `b_i` |
| op_i | input | 4 | Operation code (see R1 to R9) |
| byte_i | input | 8 | Loaded byte to widen |
| byte_signed_i | input | 1 | 1 = sign-extend the byte, 0 = zero-extend it |
| result_o | output | 32 | Operation result |
| trap_o | output | 1 | Signed-overflow trap for the trapping add and subtract |
| byte_ext_o | output | 32 | Widened byte |

## Verification
Every output is combinational. The result, the trap flag and the widened byte are all due in the same cycle in which the inputs change, with no register on the way. The bench applies each input set just after a falling clock edge and samples the outputs one time unit later, well before the next rising edge. No check therefore depends on ordering at an edge. Expected values come from bench functions that use wide signed and unsigned arithmetic instead of sign-bit rules.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

   typedef enum logic [3:0] {
      OP_ADD_T  = 4'd0,
      OP_ADD_N  = 4'd1,
      OP_SUB_T  = 4'd2,
      OP_SUB_N  = 4'd3,
      OP_LT_S   = 4'd4,
      OP_LT_U   = 4'd5,
      OP_AND    = 4'd6,
      OP_OR     = 4'd7,
      OP_XOR    = 4'd8,
      OP_NOR    = 4'd9
   } alu_op_e;

   typedef enum logic [1:0] {
      BW_AND = 2'd0,
      BW_OR  = 2'd1,
      BW_XOR = 2'd2,
      BW_NOR = 2'd3
   } bw_sel_e;

   // Bitwise group takes zero-extended immediates (R6)
   function automatic logic op_is_bitwise(input logic [3:0] op);
      return (op >= 4'd6) && (op <= 4'd9);
   endfunction

   // Operations that run the adder in subtract mode
   function automatic logic op_uses_sub(input logic [3:0] op);
      return (op >= 4'd2) && (op <= 4'd5);
   endfunction

   function automatic logic op_traps(input logic [3:0] op);
      return (op == 4'd0) || (op == 4'd2);
   endfunction

endpackage

// File: rtl/alu_opnd_prep.sv
module alu_opnd_prep
   import int_alu_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int IMM_W  = 16
) (
   input  logic [DATA_W-1:0] reg_b_i,
   input  logic [IMM_W-1:0]  imm_i,
   input  logic              use_imm_i,
   input  logic [3:0]        op_i,
   output logic [DATA_W-1:0] opnd_o
);
   localparam int PAD_W = DATA_W - IMM_W;

   logic [DATA_W-1:0] imm_wide;
   logic              fill_bit;

   always_comb begin
      fill_bit = op_is_bitwise(op_i) ? 1'b0 : imm_i[IMM_W-1];
   end

   generate
      if (PAD_W > 0) begin : g_pad
         assign imm_wide = {{PAD_W{fill_bit}}, imm_i};
      end else begin : g_nopad
         assign imm_wide = imm_i[DATA_W-1:0];
         logic unused_fill;
         assign unused_fill = fill_bit;
      end
   endgenerate

   assign opnd_o = use_imm_i ? imm_wide : reg_b_i;

   generate
      if (PAD_W > 0) begin : g_chk
         always_comb begin
            if (use_imm_i && op_is_bitwise(op_i))
               assert_imm_zext_R6: assert (opnd_o[DATA_W-1:IMM_W] == '0)
                  else $error("bitwise immediate not zero-extended");
            if (use_imm_i && !op_is_bitwise(op_i))
               assert_imm_sext_R6: assert (opnd_o[DATA_W-1] == imm_i[IMM_W-1])
                  else $error("arith immediate not sign-extended");
         end
      end
   endgenerate

endmodule

// File: rtl/alu_byte_ext.sv
module alu_byte_ext #(
   parameter int DATA_W = 32,
   parameter int BYTE_W = 8
) (
   input  logic [BYTE_W-1:0] byte_i,
   input  logic              signed_i,
   output logic [DATA_W-1:0] wide_o
);
   localparam int PAD_W = DATA_W - BYTE_W;

   logic fill_bit;
   assign fill_bit = signed_i & byte_i[BYTE_W-1];

   generate
      if (PAD_W > 0) begin : g_pad
         assign wide_o = {{PAD_W{fill_bit}}, byte_i};
      end else begin : g_nopad
         assign wide_o = byte_i[DATA_W-1:0];
         logic unused_fill;
         assign unused_fill = fill_bit;
      end
   endgenerate

   always_comb begin
      assert_byte_low_R8: assert (wide_o[BYTE_W-1:0] == byte_i)
         else $error("byte field altered");
      if (!signed_i)
         assert_byte_zext_R8: assert (wide_o[DATA_W-1] == 1'b0 || PAD_W == 0)
            else $error("unsigned byte produced a set top bit");
   end

endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
   parameter int DATA_W       = 32,
   parameter bit RIPPLE_CHAIN = 1'b0
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic              sub_i,
   output logic [DATA_W-1:0] sum_o,
   output logic              carry_o,
   output logic              ovf_o
);
   localparam int MSB = DATA_W - 1;

   logic [DATA_W-1:0] b_eff;
   assign b_eff = sub_i ? ~b_i : b_i;

   generate
      if (RIPPLE_CHAIN) begin : g_ripple
         logic [DATA_W:0] c;
         assign c[0] = sub_i;
         for (genvar i = 0; i < DATA_W; i++) begin : g_bit
            assign sum_o[i] = a_i[i] ^ b_eff[i] ^ c[i];
            assign c[i+1]   = (a_i[i] & b_eff[i]) | (c[i] & (a_i[i] ^ b_eff[i]));
         end
         assign carry_o = c[DATA_W];
      end else begin : g_behav
         logic [DATA_W:0] full;
         assign full    = {1'b0, a_i} + {1'b0, b_eff} + {{DATA_W{1'b0}}, sub_i};
         assign sum_o   = full[DATA_W-1:0];
         assign carry_o = full[DATA_W];
      end
   endgenerate

   // Same-sign inputs to the adder with a flipped result sign
   assign ovf_o = (a_i[MSB] == b_eff[MSB]) && (sum_o[MSB] != a_i[MSB]);

   always_comb begin
      if (ovf_o)
         assert_ovf_sign_R2: assert (a_i[MSB] != sum_o[MSB])
            else $error("overflow without sign change");
   end

endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise
   import int_alu_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  bw_sel_e           sel_i,
   output logic [DATA_W-1:0] y_o
);
   always_comb begin
      unique case (sel_i)
         BW_AND:  y_o = a_i & b_i;
         BW_OR:   y_o = a_i | b_i;
         BW_XOR:  y_o = a_i ^ b_i;
         default: y_o = ~(a_i | b_i);
      endcase
   end

   always_comb begin
      if (sel_i == BW_NOR)
         assert_nor_zero_R7: assert ((y_o & (a_i | b_i)) == '0)
            else $error("NOR set a bit with a one input");
   end

endmodule

// File: rtl/int_alu.sv
module int_alu
   import int_alu_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter int IMM_W        = 16,
   parameter int BYTE_W       = 8,
   parameter bit RIPPLE_CHAIN = 1'b0
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic [IMM_W-1:0]  imm_i,
   input  logic              use_imm_i,
   input  logic [3:0]        op_i,
   input  logic [BYTE_W-1:0] byte_i,
   input  logic              byte_signed_i,
   output logic [DATA_W-1:0] result_o,
   output logic              trap_o,
   output logic [DATA_W-1:0] byte_ext_o
);
   localparam int MSB = DATA_W - 1;

   initial begin
      assert_param_widths: assert (DATA_W >= 2 && IMM_W >= 1 && IMM_W <= DATA_W
                                   && BYTE_W >= 1 && BYTE_W <= DATA_W)
         else $error("int_alu: illegal width parameters");
   end

   logic [DATA_W-1:0] opnd_b;
   logic [DATA_W-1:0] sum;
   logic              carry;
   logic              ovf;
   logic [DATA_W-1:0] bw_y;
   bw_sel_e           bw_sel;
   logic              lt_signed;
   logic              lt_unsigned;

   alu_opnd_prep #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_prep (
      .reg_b_i  (b_i),
      .imm_i    (imm_i),
      .use_imm_i(use_imm_i),
      .op_i     (op_i),
      .opnd_o   (opnd_b)
   );

   alu_addsub #(.DATA_W(DATA_W), .RIPPLE_CHAIN(RIPPLE_CHAIN)) u_addsub (
      .a_i    (a_i),
      .b_i    (opnd_b),
      .sub_i  (op_uses_sub(op_i)),
      .sum_o  (sum),
      .carry_o(carry),
      .ovf_o  (ovf)
   );

   always_comb begin
      case (op_i)
         4'd6:    bw_sel = BW_AND;
         4'd7:    bw_sel = BW_OR;
         4'd8:    bw_sel = BW_XOR;
         default: bw_sel = BW_NOR;
      endcase
   end

   alu_bitwise #(.DATA_W(DATA_W)) u_bitwise (
      .a_i  (a_i),
      .b_i  (opnd_b),
      .sel_i(bw_sel),
      .y_o  (bw_y)
   );

   alu_byte_ext #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_byte (
      .byte_i  (byte_i),
      .signed_i(byte_signed_i),
      .wide_o  (byte_ext_o)
   );

   // Compare from the subtract: signed uses sign xor overflow, unsigned uses borrow
   assign lt_signed   = sum[MSB] ^ ovf;
   assign lt_unsigned = ~carry;

   always_comb begin
      result_o = '0;
      case (op_i)
         4'd0, 4'd1, 4'd2, 4'd3: result_o = sum;
         4'd4:                   result_o = {{(DATA_W-1){1'b0}}, lt_signed};
         4'd5:                   result_o = {{(DATA_W-1){1'b0}}, lt_unsigned};
         4'd6, 4'd7, 4'd8, 4'd9: result_o = bw_y;
         default:                result_o = '0;
      endcase
   end

   assign trap_o = ovf & op_traps(op_i);

   always_comb begin
      if (op_i == 4'd1 || op_i == 4'd3)
         assert_no_trap_unsigned_R3: assert (!trap_o)
            else $error("non-trapping op raised trap");
      if (!(op_i == 4'd0 || op_i == 4'd2))
         assert_trap_ops_only_R10: assert (!trap_o)
            else $error("trap on an op that cannot trap");
      if (op_i == 4'd4 || op_i == 4'd5)
         assert_lt_word_R5: assert (result_o[DATA_W-1:1] == '0)
            else $error("compare result not 0 or 1");
      if (op_i >= 4'd10)
         assert_unused_op_R9: assert (result_o == '0)
            else $error("unused op gave nonzero result");
   end

endmodule

// File: tb/int_alu_bench.sv
module int_alu_bench;
   localparam int CLK_PERIOD = 10;
   localparam int MAX_CYCLES = 200000;

   logic        clk = 1'b0;
   logic [31:0] a_i = '0, b_i = '0;
   logic [15:0] imm_i = '0;
   logic        use_imm_i = 1'b0;
   logic [3:0]  op_i = '0;
   logic [7:0]  byte_i = '0;
   logic        byte_signed_i = 1'b0;
   logic [31:0] result_o, byte_ext_o;
   logic        trap_o;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   int_alu u_int_alu (
      .a_i(a_i), .b_i(b_i), .imm_i(imm_i), .use_imm_i(use_imm_i), .op_i(op_i),
      .byte_i(byte_i), .byte_signed_i(byte_signed_i),
      .result_o(result_o), .trap_o(trap_o), .byte_ext_o(byte_ext_o)
   );

   function automatic logic [31:0] m_opnd(input logic [31:0] b, input logic [15:0] imm,
                                          input logic ui, input logic [3:0] op);
      if (!ui) return b;
      if (op >= 4'd6 && op <= 4'd9) return {16'h0, imm};
      return {{16{imm[15]}}, imm};
   endfunction

   function automatic logic [31:0] m_result(input logic [31:0] a, input logic [31:0] b,
                                            input logic [3:0] op);
      case (op)
         4'd0, 4'd1: return a + b;
         4'd2, 4'd3: return a - b;
         4'd4: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
         4'd5: return (a < b) ? 32'd1 : 32'd0;
         4'd6: return a & b;
         4'd7: return a | b;
         4'd8: return a ^ b;
         4'd9: return ~(a | b);
         default: return 32'd0;
      endcase
   endfunction

   function automatic logic m_trap(input logic [31:0] a, input logic [31:0] b,
                                   input logic [3:0] op);
      longint sa, sb, r;
      sa = longint'($signed(a));
      sb = longint'($signed(b));
      if (op == 4'd0) r = sa + sb;
      else if (op == 4'd2) r = sa - sb;
      else return 1'b0;
      return (r > 64'sd2147483647) || (r < -64'sd2147483648);
   endfunction

   function automatic logic [31:0] m_byte(input logic [7:0] v, input logic s);
      return s ? {{24{v[7]}}, v} : {24'h0, v};
   endfunction

   function automatic string op_tag(input logic [3:0] op);
      case (op)
         4'd0, 4'd1: return "R1";
         4'd2, 4'd3: return "R3";
         4'd4: return "R4";
         4'd5: return "R5";
         4'd6, 4'd7, 4'd8, 4'd9: return "R7";
         default: return "R9";
      endcase
   endfunction

   task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
      end
   endtask

   task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic [15:0] imm,
                        input logic ui, input logic [3:0] op, input logic [7:0] by,
                        input logic bs);
      @(negedge clk);
      a_i = a; b_i = b; imm_i = imm; use_imm_i = ui; op_i = op;
      byte_i = by; byte_signed_i = bs;
      #1;
   endtask

   task automatic run_vec(input string tag, input logic [31:0] a, input logic [31:0] b,
                          input logic [15:0] imm, input logic ui, input logic [3:0] op,
                          input logic [7:0] by, input logic bs);
      logic [31:0] bb;
      apply(a, b, imm, ui, op, by, bs);
      bb = m_opnd(b, imm, ui, op);
      check32(tag, result_o, m_result(a, bb, op));
      check32((op == 4'd0 || op == 4'd2) ? "R2" : "R10", {31'h0, trap_o},
              {31'h0, m_trap(a, bb, op)});
      check32("R8", byte_ext_o, m_byte(by, bs));
   endtask

   initial begin
      void'($urandom(32'h1A2B3C4D));
      // Idle state: all-zero inputs
      #1;
      check32("R1", result_o, 32'h0);
      check32("R10", {31'h0, trap_o}, 32'h0);

      // R4 / R5 corner: -1 versus 1
      run_vec("R4", 32'hFFFF_FFFF, 32'h1, 16'h0, 1'b0, 4'd4, 8'h00, 1'b0);
      check32("R4", result_o, 32'h1);
      run_vec("R5", 32'hFFFF_FFFF, 32'h1, 16'h0, 1'b0, 4'd5, 8'h00, 1'b0);
      check32("R5", result_o, 32'h0);
      // R2 add overflow, R3 same bits no trap
      run_vec("R1", 32'h7FFF_FFFF, 32'h1, 16'h0, 1'b0, 4'd0, 8'h00, 1'b0);
      check32("R2", {31'h0, trap_o}, 32'h1);
      run_vec("R1", 32'h7FFF_FFFF, 32'h1, 16'h0, 1'b0, 4'd1, 8'h00, 1'b0);
      check32("R3", {31'h0, trap_o}, 32'h0);
      check32("R1", result_o, 32'h8000_0000);
      // R2 subtract overflow and its non-trapping twin
      run_vec("R3", 32'h8000_0000, 32'h1, 16'h0, 1'b0, 4'd2, 8'h00, 1'b0);
      check32("R2", {31'h0, trap_o}, 32'h1);
      run_vec("R3", 32'h8000_0000, 32'h1, 16'h0, 1'b0, 4'd3, 8'h00, 1'b0);
      check32("R3", {31'h0, trap_o}, 32'h0);
      // R2 no overflow when signs differ on add
      run_vec("R1", 32'h7FFF_FFFF, 32'hFFFF_FFFF, 16'h0, 1'b0, 4'd0, 8'h00, 1'b0);
      check32("R2", {31'h0, trap_o}, 32'h0);
      // R6 sign-extended immediate on non-trapping add and unsigned compare
      run_vec("R6", 32'h0000_0010, 32'h0, 16'h8000, 1'b1, 4'd1, 8'h00, 1'b0);
      check32("R6", result_o, 32'hFFFF_8010);
      run_vec("R6", 32'h0000_0010, 32'h0, 16'hFFFF, 1'b1, 4'd5, 8'h00, 1'b0);
      check32("R6", result_o, 32'h1);
      // R6 zero-extended immediate on bitwise ops
      run_vec("R6", 32'hFFFF_FFFF, 32'h0, 16'h8001, 1'b1, 4'd6, 8'h00, 1'b0);
      check32("R6", result_o, 32'h0000_8001);
      run_vec("R6", 32'h0, 32'h0, 16'h8000, 1'b1, 4'd9, 8'h00, 1'b0);
      check32("R7", result_o, 32'hFFFF_7FFF);
      // R7 NOR truth pattern
      run_vec("R7", 32'h0000_00F0, 32'h0000_00CC, 16'h0, 1'b0, 4'd9, 8'h00, 1'b0);
      check32("R7", result_o, 32'hFFFF_FF03);
      // R8 byte 0x84
      run_vec("R8", 32'h0, 32'h0, 16'h0, 1'b0, 4'd7, 8'h84, 1'b1);
      check32("R8", byte_ext_o, 32'hFFFF_FF84);
      run_vec("R8", 32'h0, 32'h0, 16'h0, 1'b0, 4'd7, 8'h84, 1'b0);
      check32("R8", byte_ext_o, 32'h0000_0084);
      // R9 unused codes
      for (int k = 10; k < 16; k++) begin
         run_vec("R9", 32'h7FFF_FFFF, 32'h1, 16'h0, 1'b0, 4'(k), 8'h00, 1'b0);
         check32("R9", result_o, 32'h0);
      end

      // Random mix
      for (int n = 0; n < 3000; n++) begin
         logic [31:0] ra, rb;
         logic [3:0]  rop;
         ra  = $urandom();
         rb  = $urandom();
         rop = 4'($urandom_range(0, 15));
         if (n % 5 == 0) rb = {ra[31], rb[30:0]};
         run_vec(op_tag(rop), ra, rb, 16'($urandom()), 1'($urandom()), rop,
                 8'($urandom()), 1'($urandom()));
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (MAX_CYCLES) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule